// File: doc/BRIEF.md
# Standby Wake-Up Detector and Receive Output Control

This block sits between a CAN-style transceiver's analog front end and its digital host pins. A mode-select input picks between normal operation and a low-power standby state. The block enables the transmitter and the main receiver, and it drives the host's receive-data line. In normal operation the receive line mirrors the main comparator: low for a dominant bus, high for a recessive bus.

In standby both the transmitter and the main receiver are off, and only a low-power bus comparator is watched. A dominant level on that comparator counts as a wake-up only if it lasts through a filter window. A valid wake-up pulls the receive line low after a flag delay. The indication is not latched: once the bus is recessive again the line returns high after a release delay, but never before a minimum low time has passed. No detection happens while the main supply is reported absent.

All durations are counted in clock cycles and set by parameters. There is no data stream through this block. Every pin is a plain level-sensitive control or status signal, so no valid/ready handshake or back-pressure applies.

Top module: `sbw_wake_detect`

## Requirements
- R1: Reset enters standby (`normal_o` = 0). After that, `normal_o` takes the inverse of `stb_i` at every rising clock edge, where `stb_i` = 1 selects standby and `stb_i` = 0 selects normal.
- R2: While in standby (`normal_o` = 0), both `tx_en_o` and `rx_en_o` are 0. `rx_en_o` becomes 1 on the same edge that sets `normal_o`.
- R3: In normal mode, `rxd_o` equals the inverse of `bus_dom_i` within the same cycle (1 = dominant on `bus_dom_i`). `lp_dom_i` has no effect on `rxd_o` in normal mode.
- R4: In standby, a dominant level on `lp_dom_i` (1 = dominant) that is sampled on fewer than `FILT_CYC` consecutive edges produces no change on `rxd_o`. A single recessive sample restarts the count.
- R5: When `lp_dom_i` is sampled dominant on `FILT_CYC` consecutive edges, `rxd_o` goes low after edge number `FLAG_CYC`. Edges are counted from 1 at the first edge that sampled dominant. This holds even if the bus goes recessive after the filter has qualified. `FLAG_CYC` must exceed `FILT_CYC`.
- R6: The wake indication is not latched. Once low, `rxd_o` returns high on the `REL_CYC`-th edge after the first edge that samples `lp_dom_i` recessive, provided R7 is already met. While the filter still sees a qualified dominant level, `rxd_o` stays low.
- R7: A wake-up low pulse on `rxd_o` lasts at least `MIN_LOW` cycles.
- R8: `tx_en_o` rises `NM_CYC` edges after the edge that set `normal_o`. It drops on the edge that returns to standby.
- R9: While `vcc_ok_i` = 0, no wake-up is detected, `rxd_o` is high in standby, and the filter count is cleared. Counting restarts from zero once the supply returns.
- R10: In standby with no wake-up in progress, `rxd_o` is held high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stb_i | input | 1 | Mode select: 1 = standby, 0 = normal |
| bus_dom_i | input | 1 | Main receive comparator, 1 = bus dominant |
| lp_dom_i | input | 1 | Low-power standby comparator, 1 = bus dominant |
| vcc_ok_i | input | 1 | Main supply present |
| rxd_o | output | 1 | Receive data / wake flag to the host, low = dominant or wake |
| tx_en_o | output | 1 | Transmitter enable |
| rx_en_o | output | 1 | Main receiver enable |
| normal_o | output | 1 | Mode status, 1 = normal, 0 = standby |

## Verification
The assertions assume that all inputs, including both comparator outputs and the supply flag, are already synchronous to `clk` and hold steady between edges. They also assume the parameters keep `FLAG_CYC` above `FILT_CYC`. The stimulus meets this by changing every input only on the falling clock edge, and it runs with one fixed parameter set that satisfies the ordering. The release checks further assume the bus stays recessive for the whole release window. Every sequence that lets the indication clear keeps `lp_dom_i` low until `rxd_o` has returned high.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_PEND = 2'd1,
    WS_LOW  = 2'd2
  } wake_st_e;
endpackage

// File: rtl/sbw_mode_ctrl.sv
module sbw_mode_ctrl #(
  parameter int NM_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_i,
  output logic standby_o,
  output logic rx_en_o,
  output logic tx_en_o
);
  localparam int CW = $clog2(NM_CYC + 1);

  logic          standby_q;
  logic [CW-1:0] nm_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      standby_q <= 1'b1;
      nm_cnt_q  <= '0;
    end else begin
      standby_q <= stb_i;
      if (stb_i || standby_q)
        nm_cnt_q <= '0;
      else if (nm_cnt_q != CW'(NM_CYC))
        nm_cnt_q <= nm_cnt_q + 1'b1;
    end
  end

  assign standby_o = standby_q;
  assign rx_en_o   = !standby_q;
  assign tx_en_o   = !standby_q && (nm_cnt_q == CW'(NM_CYC));

  // R2: standby keeps both paths quiet
  a_r2_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    standby_q |-> (!tx_en_o && !rx_en_o));

  // R8: transmitter only comes up after the receiver has been on
  a_r8_tx_after_rx: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en_o) |-> (rx_en_o && $past(rx_en_o)));
endmodule

// File: rtl/sbw_wake_filter.sv
module sbw_wake_filter #(
  parameter int FILT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic lp_dom_i,
  output logic wake_det_o
);
  localparam int FW = $clog2(FILT_CYC + 1);

  logic [FW-1:0] dom_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dom_cnt_q <= '0;
    else if (!en_i || !lp_dom_i)
      dom_cnt_q <= '0;
    else if (dom_cnt_q != FW'(FILT_CYC))
      dom_cnt_q <= dom_cnt_q + 1'b1;
  end

  assign wake_det_o = (dom_cnt_q == FW'(FILT_CYC));

  // R4: qualification only follows a sampled dominant level while enabled
  a_r4_det_needs_dom: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_det_o) |-> ($past(lp_dom_i) && $past(en_i)));
endmodule

// File: rtl/sbw_rxd_shaper.sv
module sbw_rxd_shaper
  import sbw_pkg::*;
#(
  parameter int FILT_CYC = 4,
  parameter int FLAG_CYC = 6,
  parameter int REL_CYC  = 3,
  parameter int MIN_LOW  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic wake_det_i,
  output logic rxd_sb_o
);
  localparam int GAP = FLAG_CYC - FILT_CYC;
  localparam int GW  = $clog2(GAP + 1);
  localparam int RW  = $clog2(REL_CYC + 1);
  localparam int LW  = $clog2(MIN_LOW + 1);

  wake_st_e      st_q;
  logic [GW-1:0] gap_q;
  logic [RW-1:0] rel_q;
  logic [LW-1:0] low_q;
  logic          rel_done, low_done;

  assign rel_done = (rel_q >= RW'(REL_CYC - 1));
  assign low_done = (low_q >= LW'(MIN_LOW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= WS_IDLE;
      gap_q <= '0;
      rel_q <= '0;
      low_q <= '0;
    end else if (!en_i) begin
      st_q  <= WS_IDLE;
      gap_q <= '0;
      rel_q <= '0;
      low_q <= '0;
    end else begin
      case (st_q)
        WS_IDLE: begin
          if (wake_det_i) begin
            if (GAP <= 1) begin
              st_q  <= WS_LOW;
              rel_q <= '0;
              low_q <= '0;
            end else begin
              st_q  <= WS_PEND;
              gap_q <= GW'(1);
            end
          end
        end
        WS_PEND: begin
          if (gap_q >= GW'(GAP - 1)) begin
            st_q  <= WS_LOW;
            rel_q <= '0;
            low_q <= '0;
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        WS_LOW: begin
          if (low_q != LW'(MIN_LOW))
            low_q <= low_q + 1'b1;
          if (wake_det_i)
            rel_q <= '0;
          else if (rel_done && low_done)
            st_q <= WS_IDLE;
          else if (rel_q != RW'(REL_CYC))
            rel_q <= rel_q + 1'b1;
        end
        default: st_q <= WS_IDLE;
      endcase
    end
  end

  assign rxd_sb_o = (st_q != WS_LOW);

  // R5: the flag only rises through a pending qualification or a direct detect
  a_r5_low_after_det: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WS_LOW && $past(st_q) != WS_LOW) |->
      ($past(st_q) == WS_PEND || $past(wake_det_i)));

  // R6: a still-qualified dominant bus keeps the flag low
  a_r6_hold_while_dom: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WS_LOW && wake_det_i && en_i) |=> (st_q == WS_LOW));
endmodule

// File: rtl/sbw_wake_detect.sv
module sbw_wake_detect #(
  parameter int FILT_CYC = 4,
  parameter int FLAG_CYC = 6,
  parameter int REL_CYC  = 3,
  parameter int MIN_LOW  = 8,
  parameter int NM_CYC   = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_i,
  input  logic bus_dom_i,
  input  logic lp_dom_i,
  input  logic vcc_ok_i,
  output logic rxd_o,
  output logic tx_en_o,
  output logic rx_en_o,
  output logic normal_o
);
  logic standby;
  logic lp_en;
  logic wake_det;
  logic rxd_sb;

  sbw_mode_ctrl #(.NM_CYC(NM_CYC)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb_i     (stb_i),
    .standby_o (standby),
    .rx_en_o   (rx_en_o),
    .tx_en_o   (tx_en_o)
  );

  assign lp_en = standby && vcc_ok_i;

  sbw_wake_filter #(.FILT_CYC(FILT_CYC)) u_filt (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (lp_en),
    .lp_dom_i   (lp_dom_i),
    .wake_det_o (wake_det)
  );

  sbw_rxd_shaper #(
    .FILT_CYC (FILT_CYC),
    .FLAG_CYC (FLAG_CYC),
    .REL_CYC  (REL_CYC),
    .MIN_LOW  (MIN_LOW)
  ) u_shape (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (lp_en),
    .wake_det_i (wake_det),
    .rxd_sb_o   (rxd_sb)
  );

  assign normal_o = !standby;
  assign rxd_o    = standby ? rxd_sb : !bus_dom_i;

  // R9: with the supply gone for a full cycle, standby shows no wake flag
  a_r9_no_wake_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    (!vcc_ok_i && $past(!vcc_ok_i) && !normal_o) |-> rxd_o);
endmodule

// File: tb/sbw_wake_detect_test.sv
module sbw_wake_detect_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb_i = 1'b1;
  logic bus_dom_i = 1'b0;
  logic lp_dom_i = 1'b0;
  logic vcc_ok_i = 1'b1;
  logic rxd_o, tx_en_o, rx_en_o, normal_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sbw_wake_detect #(
    .FILT_CYC(4), .FLAG_CYC(6), .REL_CYC(3), .MIN_LOW(8), .NM_CYC(5)
  ) uut (
    .clk(clk), .rst_n(rst_n), .stb_i(stb_i), .bus_dom_i(bus_dom_i),
    .lp_dom_i(lp_dom_i), .vcc_ok_i(vcc_ok_i), .rxd_o(rxd_o),
    .tx_en_o(tx_en_o), .rx_en_o(rx_en_o), .normal_o(normal_o)
  );

  typedef struct packed {
    logic [7:0] reps;
    logic       stb;
    logic       bdom;
    logic       ldom;
    logic       vcc;
    logic       e_rxd;
    logic       e_tx;
    logic       e_rx;
    logic       e_norm;
    logic [3:0] req;
  } row_t;

  localparam int NROWS = 28;
  localparam row_t TBL [NROWS] = '{
    '{8'd1,  1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b0, 4'd10}, // R10 idle standby
    '{8'd3,  1'b1,1'b0,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0, 4'd4},  // R4 short dominant
    '{8'd9,  1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b0, 4'd4},  // R4 no activity after
    '{8'd5,  1'b1,1'b0,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0, 4'd5},  // R5 before flag edge
    '{8'd1,  1'b1,1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0, 4'd5},  // R5 flag edge 6
    '{8'd14, 1'b1,1'b0,1'b1,1'b1, 1'b0,1'b0,1'b0,1'b0, 4'd6},  // R6 held while dominant
    '{8'd2,  1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b0, 4'd6},  // R6 release pending
    '{8'd1,  1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b0, 4'd6},  // R6 one edge early
    '{8'd1,  1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b0, 4'd6},  // R6 released
    '{8'd4,  1'b1,1'b0,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0, 4'd4},  // R4 exactly filter
    '{8'd1,  1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b0, 4'd5},  // R5 pending
    '{8'd1,  1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b0, 4'd5},  // R5 flag after release
    '{8'd7,  1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b0, 4'd7},  // R7 min low holds
    '{8'd1,  1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b0, 4'd7},  // R7 released at min
    '{8'd10, 1'b1,1'b0,1'b1,1'b0, 1'b1,1'b0,1'b0,1'b0, 4'd9},  // R9 no supply
    '{8'd1,  1'b1,1'b0,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0, 4'd9},  // R9 restart count
    '{8'd4,  1'b1,1'b0,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0, 4'd9},  // R9 count from zero
    '{8'd1,  1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b0, 4'd5},  // R5 flag edge 6
    '{8'd7,  1'b1,1'b0,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b0, 4'd7},  // R7
    '{8'd1,  1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b0, 4'd7},  // R7
    '{8'd1,  1'b0,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b1,1'b1, 4'd1},  // R1 to normal
    '{8'd4,  1'b0,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b1,1'b1, 4'd8},  // R8 tx still off
    '{8'd1,  1'b0,1'b0,1'b0,1'b1, 1'b1,1'b1,1'b1,1'b1, 4'd8},  // R8 tx on
    '{8'd1,  1'b0,1'b1,1'b0,1'b1, 1'b0,1'b1,1'b1,1'b1, 4'd3},  // R3 dominant
    '{8'd1,  1'b0,1'b0,1'b0,1'b1, 1'b1,1'b1,1'b1,1'b1, 4'd3},  // R3 recessive
    '{8'd6,  1'b0,1'b0,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b1, 4'd3},  // R3 lp ignored
    '{8'd1,  1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b0, 4'd2},  // R2 back to standby
    '{8'd1,  1'b1,1'b0,1'b0,1'b1, 1'b1,1'b0,1'b0,1'b0, 4'd2}   // R2 stays quiet
  };

  task automatic chk(input string tag, input string sig, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, sig, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string tag, input logic r, input logic t,
                         input logic x, input logic n);
    chk(tag, "rxd_o", rxd_o, r);
    chk(tag, "tx_en_o", tx_en_o, t);
    chk(tag, "rx_en_o", rx_en_o, x);
    chk(tag, "normal_o", normal_o, n);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    // R1 R2 R10: reset state
    repeat (3) @(negedge clk);
    chk_all("R1", 1'b1, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NROWS; i++) begin
      stb_i     = TBL[i].stb;
      bus_dom_i = TBL[i].bdom;
      lp_dom_i  = TBL[i].ldom;
      vcc_ok_i  = TBL[i].vcc;
      for (int k = 0; k < int'(TBL[i].reps); k++) @(negedge clk);
      chk_all($sformatf("R%0d row%0d", TBL[i].req, i),
              TBL[i].e_rxd, TBL[i].e_tx, TBL[i].e_rx, TBL[i].e_norm);
    end

    // R3: normal-mode receive path follows within the cycle
    stb_i = 1'b0; lp_dom_i = 1'b0; bus_dom_i = 1'b0;
    repeat (2) @(negedge clk);
    bus_dom_i = 1'b1;
    #1;
    chk("R3 same cycle", "rxd_o", rxd_o, 1'b0);
    bus_dom_i = 1'b0;
    #1;
    chk("R3 same cycle", "rxd_o", rxd_o, 1'b1);

    // R1: reset during normal returns to standby
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_all("R1 mid reset", 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", "normal_o", normal_o, 1'b1);

    // R4: one recessive sample restarts the filter (3 + 3 dominant edges)
    stb_i = 1'b1;
    @(negedge clk);
    lp_dom_i = 1'b1;
    repeat (3) @(negedge clk);
    lp_dom_i = 1'b0;
    @(negedge clk);
    lp_dom_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R4 restart", "rxd_o", rxd_o, 1'b1);
    end
    lp_dom_i = 1'b0;
    repeat (12) @(negedge clk);
    chk("R10 idle", "rxd_o", rxd_o, 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule